// File: doc/BRIEF.md
# Tuner Control I2C Slave

This block is the serial control port of a frequency synthesizer. It is an I2C slave, run from a fast system clock, that holds every control field of the synthesizer: a 15-bit feedback divider word, a reference ratio code, a pump current code, band and IF selects, a test enable and four port bits. It also returns a one-byte status word that carries a power-on flag and a lock flag.

Written bytes come in pairs, and the top bit of the first byte in each pair sets what the pair means. With the top bit clear, the pair loads the divider word. With it set, the pair loads the two control bytes. A transfer may carry any number of pairs after a single address byte. The divider word changes in one step, so that a loop being retuned never sees a half-written value.

The two low address bits come from a strap input, which lets up to four devices share one bus. The SCL and SDA lines are resynchronised into the system clock. The slave drives SDA only by pulling it low.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: The slave answers only the 7-bit address 1 1 0 0 0 strap[1] strap[0], sent MSB first and followed by the R/W bit (0 = write, 1 = read). A matching address is ACKed by pulling SDA low during the ninth clock. Any other address gets no ACK, and the bytes that follow it do not change any output.
- R2: In write mode, every complete data byte is ACKed.
- R3: A first-of-pair byte whose bit 7 is 0 carries divider bits 14..8 in its bits 6..0. The next byte carries divider bits 7..0.
- R4: A first-of-pair byte whose bit 7 is 1 is control byte A: bits 6..5 are the pump code and bits 4..0 are the reference code. The byte after it is control byte B: bit 7 is the IF select, bits 6..5 are the band select, bit 4 is the test enable and bits 3..0 are the port bits.
- R5: After one address byte, any number of pairs can follow, and each pair is decoded by R3/R4 until STOP.
- R6: The divider output does not change after a high byte alone. It changes when the low byte completes. If a STOP follows a lone high byte, the divider takes the new bits 14..8 and keeps the old bits 7..0.
- R7: A STOP inside a byte discards the partial byte and leaves every output unchanged.
- R8: A read returns the status byte {por, lock, 000000}, MSB first. Each master ACK is followed by another status byte.
- R9: After the master NACKs a status byte, the slave releases SDA until the next START.
- R10: The power-on flag is 1 after reset. A STOP that ends a read transfer clears it. A write transfer leaves it unchanged.
- R11: After reset, all register outputs are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low supply-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap bits |
| lock_i | input | 1 | Loop lock indication |
| div_o | output | 15 | Feedback divider word |
| ref_code_o | output | 5 | Reference ratio code |
| pump_code_o | output | 2 | Pump current code |
| if_sel_o | output | 1 | IF passband select |
| band_o | output | 2 | Band select |
| test_en_o | output | 1 | Test enable |
| port_o | output | 4 | Port / test bits |

## Verification
The assertions assume that SCL stays at each level for many more system clocks than the synchroniser depth. They also assume that SDA changes only while SCL is low, except at START and STOP, and that the master releases SDA while the slave drives an ACK or a status bit. The bench master meets these conditions. It changes its outputs on negative clock edges, holds each quarter of an SCL period for eight system clocks, and moves SDA only in the middle of the low phase. Random byte pairs are mixed with directed cases: a lone high byte, a STOP inside a byte, a wrong address, and reads that end with a NACK.

// File: rtl/tctl_pkg.sv
package tctl_pkg;
   localparam int DIV_W    = 15;
   localparam int DIV_HI_W = DIV_W - 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
   } bus_state_t;

   typedef struct packed {
      logic       if_sel;
      logic [1:0] band;
      logic       test_en;
      logic [3:0] ports;
   } ctl_b_t;
endpackage

// File: rtl/tctl_sync.sv
module tctl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_depth
      $error("tctl_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tctl_line_events.sv
module tctl_line_events #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int NLINES = 2;
   logic [NLINES-1:0] raw, synced;
   logic scl_prev_q, sda_prev_q, scl_s, sda_s;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      tctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_i(raw[g]), .q_o(synced[g]));
   end

   assign scl_s = synced[0];
   assign sda_s = synced[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= scl_s;
         sda_prev_q <= sda_s;
      end
   end

   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_prev_q;
   assign scl_fall_o = ~scl_s & scl_prev_q;
   assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
   assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/tctl_bus_engine.sv
module tctl_bus_engine
   import tctl_pkg::*;
#(
   parameter logic [4:0] DEV_ID = 5'b11000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s_i,
   input  logic       scl_rise_i,
   input  logic       scl_fall_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic [1:0] strap_i,
   input  logic       lock_i,
   output logic       sda_pull_o,
   output logic       byte_v_o,
   output logic [7:0] byte_o,
   output logic       addr_w_o
);
   bus_state_t state_q;
   logic [7:0] sh_q, tx_q;
   logic [2:0] cnt_q;
   logic       full_q, pull_q, rw_q, mack_q, rd_seen_q, por_q;
   logic [7:0] status_w;

   assign status_w = {por_q, lock_i, 6'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sh_q      <= '0;
         tx_q      <= '0;
         cnt_q     <= '0;
         full_q    <= 1'b0;
         pull_q    <= 1'b0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         rd_seen_q <= 1'b0;
         por_q     <= 1'b1;
         byte_v_o  <= 1'b0;
         byte_o    <= '0;
         addr_w_o  <= 1'b0;
      end else begin
         byte_v_o <= 1'b0;
         addr_w_o <= 1'b0;
         if (stop_i) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
            full_q  <= 1'b0;
            if (rd_seen_q) begin
               por_q     <= 1'b0;
               rd_seen_q <= 1'b0;
            end
         end else if (start_i) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            pull_q  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WR: begin
                  if (scl_rise_i && !full_q) begin
                     sh_q  <= {sh_q[6:0], sda_s_i};
                     cnt_q <= cnt_q + 3'd1;
                     if (cnt_q == 3'd7) full_q <= 1'b1;
                  end else if (scl_fall_i && full_q) begin
                     full_q <= 1'b0;
                     cnt_q  <= '0;
                     if (state_q == ST_ADDR) begin
                        if (sh_q[7:1] == {DEV_ID, strap_i}) begin
                           pull_q  <= 1'b1;
                           rw_q    <= sh_q[0];
                           state_q <= ST_AACK;
                           if (sh_q[0]) rd_seen_q <= 1'b1;
                           else         addr_w_o  <= 1'b1;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        byte_v_o <= 1'b1;
                        byte_o   <= sh_q;
                        pull_q   <= 1'b1;
                        state_q  <= ST_WACK;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall_i) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        pull_q  <= ~status_w[7];
                        tx_q    <= {status_w[6:0], 1'b0};
                        state_q <= ST_RD;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_WR;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall_i) begin
                     pull_q  <= 1'b0;
                     state_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall_i) begin
                     cnt_q <= cnt_q + 3'd1;
                     if (cnt_q == 3'd7) begin
                        pull_q  <= 1'b0;
                        state_q <= ST_RACK;
                     end else begin
                        pull_q <= ~tx_q[7];
                        tx_q   <= {tx_q[6:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise_i) begin
                     mack_q <= ~sda_s_i;
                  end else if (scl_fall_i) begin
                     if (mack_q) begin
                        cnt_q   <= '0;
                        pull_q  <= ~status_w[7];
                        tx_q    <= {status_w[6:0], 1'b0};
                        state_q <= ST_RD;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  pull_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;

   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !pull_q);
   assert_write_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_v_o |-> (pull_q && !rw_q));
   assert_por_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_q) |-> $past(stop_i));
   assert_no_addr_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_w_o |-> (state_q == ST_AACK));
endmodule

// File: rtl/tctl_regs.sv
module tctl_regs
   import tctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_v_i,
   input  logic [7:0]       byte_i,
   input  logic             addr_w_i,
   input  logic             stop_i,
   output logic [DIV_W-1:0] div_o,
   output logic [4:0]       ref_o,
   output logic [1:0]       pump_o,
   output ctl_b_t           ctl_b_o
);
   logic                second_q, is_div_q, hv_q;
   logic [DIV_HI_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         is_div_q <= 1'b0;
         hv_q     <= 1'b0;
         hi_q     <= '0;
         div_o    <= '0;
         ref_o    <= '0;
         pump_o   <= '0;
         ctl_b_o  <= '0;
      end else if (stop_i) begin
         second_q <= 1'b0;
         if (hv_q) begin
            div_o <= {hi_q, div_o[7:0]};
            hv_q  <= 1'b0;
         end
      end else if (addr_w_i) begin
         second_q <= 1'b0;
      end else if (byte_v_i) begin
         if (!second_q) begin
            second_q <= 1'b1;
            is_div_q <= ~byte_i[7];
            if (!byte_i[7]) begin
               hi_q <= byte_i[DIV_HI_W-1:0];
               hv_q <= 1'b1;
            end else begin
               pump_o <= byte_i[6:5];
               ref_o  <= byte_i[4:0];
            end
         end else begin
            second_q <= 1'b0;
            if (is_div_q) begin
               div_o <= {hi_q, byte_i};
               hv_q  <= 1'b0;
            end else begin
               ctl_b_o <= ctl_b_t'(byte_i);
            end
         end
      end
   end

   assert_div_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_o) |-> $past(byte_v_i || stop_i));
   assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ctl_b_o, ref_o, pump_o}) |-> $past(byte_v_i));
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
   import tctl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] DEV_ID      = 5'b11000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_pull_o,
   input  logic [1:0]       strap_i,
   input  logic             lock_i,
   output logic [DIV_W-1:0] div_o,
   output logic [4:0]       ref_code_o,
   output logic [1:0]       pump_code_o,
   output logic             if_sel_o,
   output logic [1:0]       band_o,
   output logic             test_en_o,
   output logic [3:0]       port_o
);
   logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic       byte_v, addr_w;
   logic [7:0] byte_d;
   ctl_b_t     ctl_b;

   tctl_line_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_p), .stop_o(stop_p));

   tctl_bus_engine #(.DEV_ID(DEV_ID)) u_engine (
      .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
      .strap_i(strap_i), .lock_i(lock_i), .sda_pull_o(sda_pull_o),
      .byte_v_o(byte_v), .byte_o(byte_d), .addr_w_o(addr_w));

   tctl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .byte_v_i(byte_v), .byte_i(byte_d),
      .addr_w_i(addr_w), .stop_i(stop_p), .div_o(div_o),
      .ref_o(ref_code_o), .pump_o(pump_code_o), .ctl_b_o(ctl_b));

   assign if_sel_o  = ctl_b.if_sel;
   assign band_o    = ctl_b.band;
   assign test_en_o = ctl_b.test_en;
   assign port_o    = ctl_b.ports;
endmodule

// File: tb/tuner_ctl_i2c_tb_top.sv
module tuner_ctl_i2c_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0]  strap = 2'b10;
   logic        lock = 1'b0;
   logic        sda_pull;
   logic [14:0] div_w;
   logic [4:0]  ref_c;
   logic [1:0]  pump_c, band;
   logic        if_sel, test_en;
   logic [3:0]  ports;
   wire         sda_bus = sda_m & ~sda_pull;

   int checks = 0, errors = 0;

   // bench model of the register fields
   logic        m_second = 0, m_isdiv = 0, m_hv = 0, m_por = 1;
   logic [6:0]  m_hi = 0;
   logic [14:0] m_div = 0;
   logic [4:0]  m_ref = 0;
   logic [1:0]  m_pump = 0;
   logic [7:0]  m_ctlb = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tuner_ctl_i2c dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .strap_i(strap), .lock_i(lock),
      .div_o(div_w), .ref_code_o(ref_c), .pump_code_o(pump_c),
      .if_sel_o(if_sel), .band_o(band), .test_en_o(test_en), .port_o(ports));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic waitq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; scl_m = 1'b1; waitq(Q);
      sda_m = 1'b0; waitq(Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic i2c_stop();
      scl_m = 1'b0; sda_m = 1'b0; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      sda_m = 1'b1; waitq(Q);
   endtask

   task automatic wbit(input logic b);
      sda_m = b; waitq(Q);
      scl_m = 1'b1; waitq(2*Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      b = sda_bus; waitq(Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      for (int i = 7; i >= 0; i--) rbit(d[i]);
      wbit(~give_ack);
   endtask

   task automatic model_byte(input logic [7:0] d);
      if (!m_second) begin
         m_second = 1; m_isdiv = ~d[7];
         if (!d[7]) begin m_hi = d[6:0]; m_hv = 1; end
         else begin m_pump = d[6:5]; m_ref = d[4:0]; end
      end else begin
         m_second = 0;
         if (m_isdiv) begin m_div = {m_hi, d}; m_hv = 0; end
         else m_ctlb = d;
      end
   endtask

   task automatic model_stop();
      m_second = 0;
      if (m_hv) begin m_div = {m_hi, m_div[7:0]}; m_hv = 0; end
   endtask

   task automatic check_all(input string req);
      chk(req, div_w, m_div);
      chk(req, {pump_c, ref_c}, {m_pump, m_ref});
      chk(req, {if_sel, band, test_en, ports}, m_ctlb);
   endtask

   task automatic write_addr(output logic ack);
      i2c_start();
      send_byte({5'b11000, strap, 1'b0}, ack);
      m_second = 0;
   endtask

   task automatic write_data(input logic [7:0] d, input string req);
      logic ack;
      send_byte(d, ack);
      chk({req, " R2 data ack"}, ack, 1'b1);
      model_byte(d);
   endtask

   task automatic do_read(input int nbytes);
      logic ack, b;
      logic [7:0] d;
      i2c_start();
      send_byte({5'b11000, strap, 1'b1}, ack);
      chk("R1 read address ack", ack, 1'b1);
      for (int i = 0; i < nbytes; i++) begin
         recv_byte(d, i != nbytes - 1);
         chk("R8 status byte", d, {m_por, lock, 6'b0});
      end
      for (int i = 0; i < 8; i++) begin
         rbit(b);
         chk("R9 released after NACK", b, 1'b1);
      end
      i2c_stop();
      m_por = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      void'($urandom(32'd20240611));
      waitq(5);
      rst_n = 1'b1;
      waitq(5);
      chk("R11 reset sda", sda_pull, 1'b0);
      check_all("R11 reset outputs");

      // divider pair, atomic update
      write_addr(ack);
      chk("R1 write address ack", ack, 1'b1);
      write_data(8'h12, "R3");
      chk("R6 no change after high byte", div_w, 15'h0000);
      write_data(8'h34, "R3");
      chk("R3 divider word", div_w, 15'h1234);
      i2c_stop();
      check_all("R3 after stop");

      // control pair
      write_addr(ack);
      write_data(8'hE5, "R4");
      write_data(8'hA9, "R4");
      i2c_stop();
      check_all("R4 control bytes");

      // several pairs in one transfer
      write_addr(ack);
      write_data(8'h7F, "R5");
      write_data(8'hFF, "R5");
      write_data(8'h9A, "R5");
      write_data(8'h56, "R5");
      write_data(8'h01, "R5");
      write_data(8'h02, "R5");
      i2c_stop();
      check_all("R5 multi pair");

      // lone high byte committed at STOP
      write_addr(ack);
      write_data(8'h55, "R6");
      chk("R6 lone high held", div_w, 15'h0102);
      i2c_stop(); model_stop();
      chk("R6 lone high at stop", div_w, 15'h5502);

      // STOP inside a byte
      write_addr(ack);
      wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b1);
      i2c_stop();
      check_all("R7 partial byte");

      // wrong address, strap changed
      strap = 2'b01;
      i2c_start();
      send_byte(8'hC4, ack);
      chk("R1 wrong address nack", ack, 1'b0);
      send_byte(8'h00, ack);
      chk("R1 ignored byte nack", ack, 1'b0);
      send_byte(8'h00, ack);
      i2c_stop();
      check_all("R1 ignored data");

      // reads: POR survives writes, cleared by read STOP
      lock = 1'b1;
      chk("R10 por after writes", m_por, 1'b1);
      do_read(2);
      lock = 1'b0;
      do_read(1);
      chk("R10 por cleared", m_por, 1'b0);

      // random pairs
      for (int t = 0; t < 20; t++) begin
         int np;
         np = 1 + int'($urandom % 3);
         write_addr(ack);
         chk("R1 random address ack", ack, 1'b1);
         for (int p = 0; p < np; p++) begin
            logic [7:0] b0, b1;
            b0 = 8'($urandom);
            b1 = 8'($urandom);
            write_data(b0, "R5 random");
            if (($urandom % 8) != 0 || p != np - 1) write_data(b1, "R5 random");
         end
         i2c_stop(); model_stop();
         check_all("R5 random transfer");
      end
      lock = 1'b1;
      do_read(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule